// File: doc/BRIEF.md
# Interrupt Status, Mask and Vector Controller

This block gathers a set of hardware event lines into a sticky status register and turns them into one level-sensitive interrupt request for a bus-attached board. Software reads the status through a small synchronous register port. It clears bits one at a time by writing ones, so several drivers can each clear only the bits they own. A mask register selects which captured events may raise the request. Status keeps recording events even while their mask bits are off, which helps with polling and debug.

When the host runs an interrupt acknowledge, the block answers with a one-cycle acknowledge pulse. It puts a software-programmed vector on a dedicated output during that pulse. Writing a one to bit 0 of the control register is a soft reset. It returns every register to its power-up default without touching the hardware reset line.

Top module: `evt_irq_ctrl`

## Requirements
- R1: A register write never sets a status bit. A status bit goes from 0 to 1 only in the cycle after its `evt_in` line was high.
- R2: A write to offset 0 clears exactly the status bits where `wdata` holds a one. Bits written with zero keep their value.
- R3: Reading any register, or leaving the port idle, never clears a status bit. Reads have no side effect.
- R4: An event sets its status bit whatever the value of its mask bit. The bit stays readable while masked.
- R5: `irq_out` is high exactly when some status bit and its mask bit are both one. It stays high until software clears those bits or clears the mask.
- R6: If an event and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R7: Writing a one to bit 0 at offset 3 resets status, mask and vector to zero on that clock edge. It also drops `irq_out` and `ack_out`. Offset 3 always reads as zero.
- R8: Register map: offset 0 is status in bits [N_EVT-1:0]; offset 1 is mask in bits [N_EVT-1:0], where 1 means enabled; offset 2 is vector in bits [VEC_W-1:0]. Every bit above a field reads back as zero, whatever was written to it.
- R9: After hardware reset, all registers read zero and `irq_out`, `ack_out` and `ack_vec` are low.
- R10: A rising edge of `ack_req` sampled while `irq_out` is high gives `ack_out` high for exactly one cycle, starting one clock later, with the vector on `ack_vec`. A request seen while `irq_out` is low gets no acknowledge. `ack_vec` is zero whenever `ack_out` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | N_EVT | Hardware event lines, sampled each clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` (combinational) |
| irq_out | output | 1 | Level interrupt request |
| ack_req | input | 1 | Interrupt acknowledge request |
| ack_out | output | 1 | One-cycle acknowledge |
| ack_vec | output | VEC_W | Vector presented with `ack_out` |

## Verification
The assertions check the status invariants on every cycle:
- no bit appears without an event;
- an idle port never drops a bit;
- a simultaneous event beats a clear;
- a written-one bit is clear afterwards unless re-raised;
- soft reset empties every register;
- acknowledge pulses are single and only follow an active request.

Other behaviour depends on particular register contents, so only the bench scenarios can show it. These cover reserved-bit readback, the exact vector value returned on acknowledge, masked events staying visible, and the absence of an acknowledge when no interrupt is pending.

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
  parameter int N_EVT  = 8,
  parameter int DATA_W = 16,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  evt_in,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_out,
  input  logic              ack_req,
  output logic              ack_out,
  output logic [VEC_W-1:0]  ack_vec
);
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_VEC  = 2'd2;
  localparam logic [1:0] A_CTRL = 2'd3;

  logic [N_EVT-1:0] stat_q, mask_q;
  logic [VEC_W-1:0] vec_q;
  logic             req_q;

  wire wr_stat  = wr_en && addr == A_STAT;
  wire wr_mask  = wr_en && addr == A_MASK;
  wire wr_vec   = wr_en && addr == A_VEC;
  wire soft_rst = wr_en && addr == A_CTRL && wdata[0];
  wire [N_EVT-1:0] clr_bits = wr_stat ? wdata[N_EVT-1:0] : '0;
  wire ack_fire = ack_req && !req_q && irq_out;

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  assign irq_out = |(stat_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      mask_q  <= '0;
      vec_q   <= '0;
      req_q   <= 1'b0;
      ack_out <= 1'b0;
      ack_vec <= '0;
    end else if (soft_rst) begin
      stat_q  <= '0;
      mask_q  <= '0;
      vec_q   <= '0;
      req_q   <= ack_req;
      ack_out <= 1'b0;
      ack_vec <= '0;
    end else begin
      stat_q  <= (stat_q & ~clr_bits) | evt_in;
      if (wr_mask) mask_q <= wdata[N_EVT-1:0];
      if (wr_vec)  vec_q  <= wdata[VEC_W-1:0];
      req_q   <= ack_req;
      ack_out <= ack_fire;
      ack_vec <= ack_fire ? vec_q : '0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_STAT:  rdata[N_EVT-1:0] = stat_q;
      A_MASK:  rdata[N_EVT-1:0] = mask_q;
      A_VEC:   rdata[VEC_W-1:0] = vec_q;
      default: rdata = '0;
    endcase
  end

  // R1
  sw_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt_in)) == '0));

  // R2
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((stat_q & $past(wdata[N_EVT-1:0]) & ~$past(evt_in)) == '0));

  // R3
  no_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (($past(stat_q) & ~stat_q) == '0));

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> (($past(evt_in) & ~stat_q) == '0));

  // R5
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !wr_en) |=> irq_out);

  // R7
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (stat_q == '0 && mask_q == '0 && vec_q == '0 && !irq_out && !ack_out));

  // R10
  ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |-> ($past(irq_out) && $past(ack_req)));

  // R10
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |=> !ack_out);
endmodule

// File: tb/evt_irq_ctrl_test.sv
module evt_irq_ctrl_test;
  localparam int N = 8, DW = 16, VW = 8;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] evt_in = '0;
  logic wr_en = 0, ack_req = 0;
  logic [1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq_out, ack_out;
  logic [VW-1:0] ack_vec;

  evt_irq_ctrl #(.N_EVT(N), .DATA_W(DW), .VEC_W(VW)) uut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_out(irq_out), .ack_req(ack_req),
    .ack_out(ack_out), .ack_vec(ack_vec));

  always #5 clk = ~clk;

  typedef struct {
    int    kind;
    int    exp;
    string tag;
  } item_t;

  item_t sb_q[$];
  int total = 0, bad = 0;
  logic chk_v = 0;
  logic done = 0;

  task automatic expect_it(input int kind, input int exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    @(posedge clk); #2;
    sb_q.push_back(it);
    chk_v = 1;
    @(posedge clk); #2;
    chk_v = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input int exp, input string tag);
    addr = a;
    expect_it(0, exp, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #2;
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #2;
    wr_en = 0; wdata = '0;
  endtask

  task automatic pulse_evt(input logic [N-1:0] v);
    @(posedge clk); #2;
    evt_in = v;
    @(posedge clk); #2;
    evt_in = '0;
  endtask

  always @(negedge clk) begin
    if (chk_v && sb_q.size() > 0) begin
      item_t it;
      int act;
      it = sb_q.pop_front();
      case (it.kind)
        0: act = int'(rdata);
        1: act = int'(irq_out);
        2: act = int'(ack_out);
        default: act = int'(ack_vec);
      endcase
      total++;
      if (act != it.exp) begin
        bad++;
        $display("FAIL %s kind=%0d actual=%0h expected=%0h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;

    // R9 reset defaults
    rd_chk(2'd0, 0, "R9 status");
    rd_chk(2'd1, 0, "R9 mask");
    rd_chk(2'd2, 0, "R9 vector");
    expect_it(1, 0, "R9 irq");
    expect_it(2, 0, "R9 ack");

    // R4 masked event still captured
    pulse_evt(8'h05);
    rd_chk(2'd0, 'h05, "R4 masked capture");
    expect_it(1, 0, "R4 no irq while masked");

    // R3 reads have no side effect
    rd_chk(2'd0, 'h05, "R3 reread");
    rd_chk(2'd0, 'h05, "R3 reread2");

    // R1 writes never set
    wr(2'd0, 16'h00F0);
    rd_chk(2'd0, 'h05, "R1 write ones on clear bits");
    wr(2'd0, 16'h0000);
    rd_chk(2'd0, 'h05, "R2 write zero no change");

    // R5 level irq
    wr(2'd1, 16'h0004);
    expect_it(1, 1, "R5 irq on enable");
    wr(2'd0, 16'h0001);
    rd_chk(2'd0, 'h04, "R2 selective clear");
    expect_it(1, 1, "R5 irq held");
    wr(2'd0, 16'h0004);
    expect_it(1, 0, "R5 irq dropped on clear");

    // R8 reserved bits
    wr(2'd1, 16'hFFFF);
    rd_chk(2'd1, 'hFF, "R8 mask reserved zero");
    wr(2'd2, 16'hFFA5);
    rd_chk(2'd2, 'hA5, "R8 vector reserved zero");
    rd_chk(2'd3, 0, "R7 control reads zero");

    // R6 set beats clear
    pulse_evt(8'h02);
    @(posedge clk); #2;
    wr_en = 1; addr = 2'd0; wdata = 16'h0002; evt_in = 8'h02;
    @(posedge clk); #2;
    wr_en = 0; wdata = '0; evt_in = '0;
    rd_chk(2'd0, 'h02, "R6 set wins");

    // R10 acknowledge
    @(posedge clk); #2 ack_req = 1;
    expect_it(2, 1, "R10 ack pulse");
    ack_req = 1;
    expect_it(2, 0, "R10 ack single cycle");
    ack_req = 0;
    @(posedge clk); #2 ack_req = 1;
    @(posedge clk); #2;
    ack_req = 0;
    wr(2'd0, 16'h00FF);
    expect_it(1, 0, "R10 irq cleared");
    @(posedge clk); #2 ack_req = 1;
    expect_it(2, 0, "R10 no ack when idle");
    expect_it(3, 0, "R10 vec zero when idle");
    ack_req = 0;

    // R7 soft reset
    pulse_evt(8'h81);
    expect_it(1, 1, "R7 irq before soft reset");
    wr(2'd3, 16'h0001);
    rd_chk(2'd0, 0, "R7 status");
    rd_chk(2'd1, 0, "R7 mask");
    rd_chk(2'd2, 0, "R7 vector");
    expect_it(1, 0, "R7 irq");
    done = 1;
  end

  initial begin : ack_vec_probe
    // R10 vector value during the acknowledge pulse
    @(posedge ack_out);
    #1;
    total++;
    if (ack_vec !== 8'hA5) begin
      bad++;
      $display("FAIL R10 vector actual=%0h expected=a5", ack_vec);
    end
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    #20;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule